// File: doc/BRIEF.md
# Partial-Word Store Byte-Lane Unit

This block turns a request to store part of a register into exactly one aligned write on a big-endian data bus, with one enable per byte. A request carries a byte address, a register value and a mode bit. The mode bit picks one of two variants. The *head* variant (mode 0) writes from the addressed byte through the last byte of the word. The *tail* variant (mode 1) writes from the first byte of the word up to, but not including, the addressed byte. The head variant takes its bytes from the low-order end of the register. The tail variant takes them from the high-order end. In both variants a byte keeps its lane position, so register bits 31:24 can only land in lane 0.

Lane 0 is the most-significant byte of the bus (bits 31:24), and enable bit 3 belongs to lane 0. A tail store at offset 0 enables no byte. It still produces one beat, with the probe flag raised and the write strobe low, so that a downstream stage can run a write-permission check and mark the line dirty. The unit does no protection, caching or translation of its own.

A two-state controller sequences each request. In `ST_IDLE` the request side is ready. The transition LOAD (request valid while idle) registers the computed beat and enters `ST_HOLD`. In `ST_HOLD` the beat is presented on the write side and held unchanged. The transition DRAIN (write-side ready while holding) returns to `ST_IDLE`. Without a ready, the controller stays in `ST_HOLD` (transition WAIT). Without a request, it stays in `ST_IDLE` (transition REST).

Top module: `pwsb_store_unit`

## Requirements
- R1: After reset, `wr_valid` and `wr_strobe` are 0 and `req_ready` is 1.
- R2: In head mode (`req_tail`=0) with address offset k (address bits 1:0), lanes k through 3 are enabled, so `wr_be` = 4'b1111 >> k. Offsets 3, 2, 1 and 0 give 1, 2, 3 and 4 bytes.
- R3: In tail mode (`req_tail`=1) with offset k of 1, 2 or 3, lanes 0 through k-1 are enabled, so `wr_be` = ~(4'b1111 >> k).
- R4: A tail store at offset 0 yields one beat with `wr_be`=0, `wr_probe`=1 and `wr_strobe`=0. `wr_probe` is 0 for every other request.
- R5: Each enabled lane L carries register bits [31-8L : 24-8L]. Every disabled lane of `wr_data` is zero.
- R6: `wr_addr` equals the request address with bits 1:0 cleared.
- R7: Every request, including the three-byte spans, produces exactly one write beat whose enabled lanes are contiguous and touch lane 0 or lane 3.
- R8: A beat appears on the write side in the cycle after its request is accepted. It holds `wr_valid` and every output field stable until `wr_ready`, and `req_ready` is 0 while the beat waits.
- R9: While `wr_valid` is 1, `wr_strobe` is 1 exactly when at least one byte enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit can take a request |
| req_addr | input | ADDR_W | Byte address of the store |
| req_data | input | DATA_W | Register value to store |
| req_tail | input | 1 | 0 = head variant, 1 = tail variant |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory side takes the beat |
| wr_addr | output | ADDR_W | Word-aligned address |
| wr_data | output | DATA_W | Lane-placed write data, unused lanes zero |
| wr_be | output | DATA_W/8 | Byte enables, MSB = lane 0 |
| wr_strobe | output | 1 | A real write is requested |
| wr_probe | output | 1 | Permission probe only, no bytes written |

## Verification
The bench sweeps both modes across all four offsets. For each case it uses four register patterns: distinct bytes, alternating bits, all ones, and only the extreme bits set. Distinct bytes reveal a byte taken from the wrong lane. All ones shows any lane that should have been zeroed. The extreme-bit value separates head-mode (low-order) from tail-mode (high-order) byte selection. The bench stalls the write side for zero to two cycles to separate a held beat from a dropped or repeated one. It counts completed beats against requests, which shows that no three-byte span is split.

// File: rtl/pwsb_pkg.sv
package pwsb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pwsb_state_e;

    typedef enum logic {
        MODE_HEAD = 1'b0,
        MODE_TAIL = 1'b1
    } pwsb_mode_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/pwsb_lane_select.sv
module pwsb_lane_select
    import pwsb_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             tail_mode,
    output logic [LANES-1:0] lane_en,
    output logic             probe_only
);

    localparam logic [LANES-1:0] LANE_ALL = '1;

    logic [LANES-1:0] from_offset;
    pwsb_mode_e       mode;

    always_comb begin
        mode        = pwsb_mode_e'(tail_mode);
        // Lanes at or after the offset; bit LANES-1 is lane 0.
        from_offset = LANE_ALL >> offset;
        probe_only  = 1'b0;
        unique case (mode)
            MODE_HEAD: lane_en = from_offset;
            MODE_TAIL: begin
                lane_en    = ~from_offset;
                probe_only = (offset == '0);
            end
            default:   lane_en = '0;
        endcase
    end

endmodule

// File: rtl/pwsb_lane_pack.sv
module pwsb_lane_pack
    import pwsb_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] reg_value,
    input  logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] lane_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane g is the g-th byte counted from the top of the bus.
        localparam int HI = DATA_W - 1 - BYTE_W * g;
        assign lane_data[HI -: BYTE_W] =
            lane_en[LANES-1-g] ? reg_value[HI -: BYTE_W] : '0;
    end

endmodule

// File: rtl/pwsb_ctrl.sv
module pwsb_ctrl
    import pwsb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_be,
    input  logic              in_probe,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be,
    output logic              out_strobe,
    output logic              out_probe
);

    pwsb_state_e state_q, state_d;
    logic        load;

    // Next-state logic: LOAD, REST, DRAIN and WAIT transitions.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (in_valid) begin
                state_d = ST_HOLD;
                load    = 1'b1;
            end
            ST_HOLD: if (out_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers, loaded once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_data   <= '0;
            out_be     <= '0;
            out_strobe <= 1'b0;
            out_probe  <= 1'b0;
        end else if (load) begin
            out_addr   <= in_addr;
            out_data   <= in_data;
            out_be     <= in_be;
            out_strobe <= |in_be;
            out_probe  <= in_probe;
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_HOLD);

endmodule

// File: rtl/pwsb_store_unit.sv
module pwsb_store_unit
    import pwsb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_tail,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [LANES-1:0]  wr_be,
    output logic              wr_strobe,
    output logic              wr_probe
);

    logic [LANES-1:0]  sel_be;
    logic              sel_probe;
    logic [DATA_W-1:0] packed_data;
    logic [ADDR_W-1:0] word_addr;

    assign word_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    pwsb_lane_select #(.LANES(LANES)) u_select (
        .offset     (req_addr[OFF_W-1:0]),
        .tail_mode  (req_tail),
        .lane_en    (sel_be),
        .probe_only (sel_probe)
    );

    pwsb_lane_pack #(.DATA_W(DATA_W)) u_pack (
        .reg_value (req_data),
        .lane_en   (sel_be),
        .lane_data (packed_data)
    );

    pwsb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_ready   (req_ready),
        .in_addr    (word_addr),
        .in_data    (packed_data),
        .in_be      (sel_be),
        .in_probe   (sel_probe),
        .out_valid  (wr_valid),
        .out_ready  (wr_ready),
        .out_addr   (wr_addr),
        .out_data   (wr_data),
        .out_be     (wr_be),
        .out_strobe (wr_strobe),
        .out_probe  (wr_probe)
    );

endmodule

// File: rtl/pwsb_store_unit_chk.sv
module pwsb_store_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_tail,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [LANES-1:0]  wr_be,
    input logic              wr_strobe,
    input logic              wr_probe
);

    localparam logic [LANES-1:0] ALL_LANES = '1;

    logic              accept;
    logic [DATA_W-1:0] be_mask;

    assign accept = req_valid && req_ready;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            be_mask[DATA_W-1-8*i -: 8] = {8{wr_be[LANES-1-i]}};
        end
    end

    assert_head_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_tail) |=> (wr_be == (ALL_LANES >> $past(req_addr[OFF_W-1:0]))));

    assert_tail_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_tail) |=> (wr_be == ~(ALL_LANES >> $past(req_addr[OFF_W-1:0]))));

    assert_probe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_probe) |-> (!wr_strobe && wr_be == '0));

    assert_idle_lanes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data & ~be_mask) == '0));

    assert_aligned_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[OFF_W-1:0] == '0));

    assert_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be == '0 || wr_be[LANES-1] || wr_be[0]) &&
                     ($countones(wr_be ^ (wr_be >> 1)) <= 2));

    assert_accept_to_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> wr_valid);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_be)
                                     && $stable(wr_addr) && $stable(wr_probe)));

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);

    assert_strobe_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_strobe == (wr_be != '0)));

endmodule

bind pwsb_store_unit pwsb_store_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_tail  (req_tail),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be),
    .wr_strobe (wr_strobe),
    .wr_probe  (wr_probe)
);

// File: tb/pwsb_store_unit_tb_top.sv
module pwsb_store_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_tail = 1'b0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic        wr_strobe;
    logic        wr_probe;

    int checks = 0;
    int fails = 0;
    int beats = 0;
    int sent = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    pwsb_store_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_tail(req_tail),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_strobe(wr_strobe), .wr_probe(wr_probe)
    );

    always @(posedge clk) if (rst_n && wr_valid && wr_ready) beats++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic run_one(input logic [31:0] addr, input logic [31:0] data,
                           input bit tail, input int stall);
        int          off;
        logic [3:0]  exp_be;
        logic [31:0] exp_data;
        logic [31:0] held;
        off = int'(addr[1:0]);
        exp_be = '0;
        exp_data = '0;
        for (int lane = 0; lane < 4; lane++) begin
            bit en;
            en = tail ? (lane < off) : (lane >= off);
            if (en) begin
                exp_be[3-lane] = 1'b1;
                exp_data[31-8*lane -: 8] = data[31-8*lane -: 8];
            end
        end
        @(negedge clk);
        req_addr = addr; req_data = data; req_tail = tail; req_valid = 1'b1;
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
        chk(wr_valid === 1'b1, "R8 beat after accept", 32'(wr_valid), 1);
        chk(req_ready === 1'b0, "R8 not ready while holding", 32'(req_ready), 0);
        if (tail) chk(wr_be === exp_be, "R3 tail enables", 32'(wr_be), 32'(exp_be));
        else      chk(wr_be === exp_be, "R2 head enables", 32'(wr_be), 32'(exp_be));
        chk(wr_data === exp_data, "R5 lane data", wr_data, exp_data);
        chk(wr_addr === {addr[31:2], 2'b00}, "R6 aligned address", wr_addr,
            {addr[31:2], 2'b00});
        chk(wr_probe === (tail && off == 0), "R4 probe flag", 32'(wr_probe),
            32'(tail && off == 0));
        chk(wr_strobe === (exp_be != 0), "R9 strobe", 32'(wr_strobe), 32'(exp_be != 0));
        held = wr_data;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(wr_valid === 1'b1 && wr_data === held && wr_be === exp_be,
                "R8 held beat", wr_data, held);
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        chk(wr_valid === 1'b0 && req_ready === 1'b1, "R8 drained",
            {30'b0, wr_valid, req_ready}, 32'h1);
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h11223344;
        pats[1] = 32'hA5C3F00F;
        pats[2] = 32'hFFFFFFFF;
        pats[3] = 32'h80000001;
        repeat (3) @(negedge clk);
        chk(wr_valid === 1'b0 && wr_strobe === 1'b0, "R1 reset outputs",
            {30'b0, wr_valid, wr_strobe}, 0);
        chk(req_ready === 1'b1, "R1 reset ready", 32'(req_ready), 1);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
                for (int p = 0; p < 4; p++) begin
                    run_one(32'h0000_1000 + 32'(p * 'h44 + m * 'h800) + 32'(o),
                            pats[p], bit'(m), (o + p) % 3);
                end
            end
        end
        // R7: one beat per request, three-byte spans included.
        chk(beats == sent, "R7 one beat per request", 32'(beats), 32'(sent));
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", beats, sent);
            summary();
            $finish;
        end
    end

endmodule